// File: doc/BRIEF.md
# Four-Level Frame Sync Detector

This block watches the stream of recovered four-level symbols on the receive side of a modem and reports when the most recent run of symbols matches a stored frame sync word. Each symbol arrives as a 2-bit code with a one-cycle valid strobe. The detector shifts every accepted symbol into a sliding window as long as the sync word. It then scores the window against the stored word. The score is not a count of differing symbols. Each position adds the number of amplitude steps between the level it expected and the level it received. A neighbouring level therefore costs one, and the far level of a pair two apart costs two.

A 2-bit tolerance code sets how large a total score still counts as a hit. The choices are zero, two, four or six, and four is the default out of reset. When the total is at or under that limit, the block raises a one-cycle detect pulse and publishes the total. Detection only runs while receive mode is selected. Leaving receive mode empties the window, and a fresh window must then fill before any hit can be reported.

Top module: `fsync_detector`

## Requirements
- R1: Codes map to levels as 2'b01 = +3, 2'b00 = +1, 2'b10 = -1, 2'b11 = -3. The mismatch of one position is the number of steps between its expected and received level, from 0 to 3.
- R2: One clock after the edge that accepts a symbol, `score` holds the sum of mismatches over all SYM_LEN window positions. Pattern bits [2i+1:2i] are compared with the i-th oldest symbol in the window, where i = 0 is the oldest. Window slots that have not yet been filled hold code 2'b00.
- R3: The tolerance code sets the largest accepted score: 2'b00 gives 0, 2'b01 gives 2, 2'b10 gives 4, and 2'b11 gives 6.
- R4: The tolerance is taken from `tol_sel` at an edge where `tol_wr` is high, and is held otherwise. Its reset value is 2'b10, which means a limit of 4.
- R5: `detect` goes high for exactly one clock, one clock after the accepting edge, when the window is full and the score is within the limit.
- R6: After reset, and after receive mode is re-entered, no detect is raised until SYM_LEN new symbols have been accepted.
- R7: While `rx_en` is low, symbols are ignored, the window is emptied, and both `detect` and `score` read 0.
- R8: A pattern written with `pat_load` is used for every score computed after the load edge.
- R9: A cycle with `sym_valid` low changes neither the window nor `score`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive mode select; detection runs only while high |
| sym_valid | input | 1 | Strobe for one received symbol |
| sym_code | input | 2 | Received symbol code |
| tol_wr | input | 1 | Load strobe for the tolerance code |
| tol_sel | input | 2 | Tolerance code |
| pat_load | input | 1 | Load strobe for the sync pattern |
| pat_data | input | 2*SYM_LEN | Sync pattern, oldest symbol in bits [1:0] |
| detect | output | 1 | One-cycle hit pulse |
| score | output | SCORE_W | Weighted mismatch total of the last evaluated window |

## Verification
The bench sets up scores that sit exactly on each tolerance limit and exactly one step above it. A detector that compares with < instead of <=, or that decodes the tolerance code wrongly, misses the first case or fires on the second. It drives two-step errors and a window that is entirely +3 against a pattern that is entirely -3, with an expected score of 72. A design that counts differing symbols or differing bits reports a smaller total there. It also checks that no hit appears on the 23rd symbol after reset or after receive mode is re-entered, and that symbols offered while receive mode is off leave the score at zero. A detector with an off-by-one fill counter, or one that keeps a stale window, fires early in these cases.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

   typedef logic [1:0] sym_code_t;
   typedef logic [1:0] level_t;

   // code -> level index, 0 = +3 ... 3 = -3 (R1)
   function automatic level_t code_to_level(input sym_code_t c);
      return {c[1], ~(c[1] ^ c[0])};
   endfunction

   function automatic logic [1:0] level_gap(input level_t a, input level_t b);
      return (a > b) ? (a - b) : (b - a);
   endfunction

endpackage

// File: rtl/fsd_window.sv
module fsd_window
   import fsd_pkg::*;
#(
   parameter int SYM_LEN = 24,
   localparam int WIN_W  = 2 * SYM_LEN,
   localparam int FILL_W = $clog2(SYM_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             sym_valid,
   input  sym_code_t        sym_code,
   output logic [WIN_W-1:0] win,
   output logic             full,
   output logic             step
);

   logic [FILL_W-1:0] fill_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !rx_en) begin
         win    <= '0;
         fill_q <= '0;
         step   <= 1'b0;
      end else begin
         step <= sym_valid;
         if (sym_valid) begin
            win <= {sym_code, win[WIN_W-1:2]};
            if (fill_q != FILL_W'(SYM_LEN))
               fill_q <= fill_q + FILL_W'(1);
         end
      end
   end

   assign full = (fill_q == FILL_W'(SYM_LEN));

   assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= FILL_W'(SYM_LEN));

   assert_fill_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_q != $past(fill_q)) |-> (fill_q == '0 || fill_q == $past(fill_q) + FILL_W'(1)));

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && !sym_valid) |=> $stable(win));

endmodule

// File: rtl/fsd_scorer.sv
module fsd_scorer
   import fsd_pkg::*;
#(
   parameter int SYM_LEN = 24,
   localparam int WIN_W   = 2 * SYM_LEN,
   localparam int SCORE_W = $clog2(3 * SYM_LEN + 1)
) (
   input  logic [WIN_W-1:0]   win,
   input  logic [WIN_W-1:0]   pat,
   output logic [SCORE_W-1:0] total
);

   logic [1:0] gap [SYM_LEN];

   for (genvar p = 0; p < SYM_LEN; p++) begin : g_pos
      assign gap[p] = level_gap(code_to_level(win[2*p +: 2]),
                                code_to_level(pat[2*p +: 2]));
   end

   always_comb begin
      total = '0;
      for (int p = 0; p < SYM_LEN; p++)
         total = total + SCORE_W'(gap[p]);
   end

endmodule

// File: rtl/fsd_decide.sv
module fsd_decide #(
   parameter int SCORE_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_en,
   input  logic               step,
   input  logic               full,
   input  logic [1:0]         tol_code,
   input  logic [SCORE_W-1:0] total,
   output logic               detect,
   output logic [SCORE_W-1:0] score
);

   logic [SCORE_W-1:0] limit;

   assign limit = SCORE_W'({tol_code, 1'b0});   // 0/2/4/6 (R3)

   always_ff @(posedge clk) begin
      if (!rst_n || !rx_en) begin
         detect <= 1'b0;
         score  <= '0;
      end else begin
         detect <= step && full && (total <= limit);
         if (step)
            score <= total;
      end
   end

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (!detect && score == '0));

   assert_detect_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      detect |-> (score <= SCORE_W'(6)));

   assert_pulse_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
      detect |-> $past(step));

endmodule

// File: rtl/fsync_detector.sv
module fsync_detector
   import fsd_pkg::*;
#(
   parameter int SYM_LEN = 24,
   localparam int WIN_W   = 2 * SYM_LEN,
   localparam int SCORE_W = $clog2(3 * SYM_LEN + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_en,
   input  logic               sym_valid,
   input  logic [1:0]         sym_code,
   input  logic               tol_wr,
   input  logic [1:0]         tol_sel,
   input  logic               pat_load,
   input  logic [WIN_W-1:0]   pat_data,
   output logic               detect,
   output logic [SCORE_W-1:0] score
);

   initial begin
      assert (SYM_LEN >= 4 && SYM_LEN <= 256)
         else $error("fsync_detector: SYM_LEN out of range");
   end

   logic [1:0]         tol_q;
   logic [WIN_W-1:0]   pat_q;
   logic [WIN_W-1:0]   win;
   logic               full;
   logic               step;
   logic [SCORE_W-1:0] total;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tol_q <= 2'b10;   // limit 4 by default (R4)
         pat_q <= '0;
      end else begin
         if (tol_wr)
            tol_q <= tol_sel;
         if (pat_load)
            pat_q <= pat_data;
      end
   end

   fsd_window #(.SYM_LEN(SYM_LEN)) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_en     (rx_en),
      .sym_valid (sym_valid),
      .sym_code  (sym_code),
      .win       (win),
      .full      (full),
      .step      (step)
   );

   fsd_scorer #(.SYM_LEN(SYM_LEN)) u_scorer (
      .win   (win),
      .pat   (pat_q),
      .total (total)
   );

   fsd_decide #(.SCORE_W(SCORE_W)) u_decide (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_en    (rx_en),
      .step     (step),
      .full     (full),
      .tol_code (tol_q),
      .total    (total),
      .detect   (detect),
      .score    (score)
   );

   assert_score_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
      score <= SCORE_W'(3 * SYM_LEN));

   assert_hold_no_sym_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && !step) |=> $stable(score));

endmodule

// File: tb/fsync_detector_tb_top.sv
module fsync_detector_tb_top;

   localparam int N  = 24;
   localparam int SW = $clog2(3 * N + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_en = 1'b0;
   logic          sym_valid = 1'b0;
   logic [1:0]    sym_code = 2'b00;
   logic          tol_wr = 1'b0;
   logic [1:0]    tol_sel = 2'b00;
   logic          pat_load = 1'b0;
   logic [2*N-1:0] pat_data = '0;
   logic          detect;
   logic [SW-1:0] score;

   int errors = 0;
   int checks = 0;

   logic [1:0] pat_m [N];
   logic [1:0] win_m [N];
   int         err_m [N];
   int         fill_m = 0;
   int         tol_m  = 2;
   bit         rx_m   = 1'b0;

   always #4 clk = ~clk;

   fsync_detector #(.SYM_LEN(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sym_valid(sym_valid),
      .sym_code(sym_code), .tol_wr(tol_wr), .tol_sel(tol_sel),
      .pat_load(pat_load), .pat_data(pat_data), .detect(detect), .score(score)
   );

   function automatic int lvl(input logic [1:0] c);
      case (c)
         2'b01:   return 0;
         2'b00:   return 1;
         2'b10:   return 2;
         default: return 3;
      endcase
   endfunction

   function automatic logic [1:0] code_of(input int l);
      case (l)
         0:       return 2'b01;
         1:       return 2'b00;
         2:       return 2'b10;
         default: return 2'b11;
      endcase
   endfunction

   // level moved by d steps (d = 1 or 2), staying in range
   function automatic logic [1:0] bend(input logic [1:0] c, input int d);
      int l = lvl(c);
      return (l + d <= 3) ? code_of(l + d) : code_of(l - d);
   endfunction

   function automatic int model_score();
      int s = 0;
      for (int i = 0; i < N; i++) begin
         int a = lvl(win_m[i]);
         int b = lvl(pat_m[i]);
         s += (a > b) ? a - b : b - a;
      end
      return s;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load_pat();
      @(negedge clk);
      for (int i = 0; i < N; i++) pat_data[2*i +: 2] = pat_m[i];
      pat_load = 1'b1;
      @(negedge clk);
      pat_load = 1'b0;
   endtask

   task automatic set_tol(input int t);
      @(negedge clk);
      tol_sel = 2'(t);
      tol_wr  = 1'b1;
      @(negedge clk);
      tol_wr = 1'b0;
      tol_m  = t;
   endtask

   task automatic set_rx(input bit on);
      @(negedge clk);
      rx_en = on;
      rx_m  = on;
      if (!on) begin
         for (int i = 0; i < N; i++) win_m[i] = 2'b00;
         fill_m = 0;
      end
      @(negedge clk);
   endtask

   int score_m = 0;

   task automatic send(input logic [1:0] c);
      bit exp_det;
      @(negedge clk);
      sym_valid = 1'b1;
      sym_code  = c;
      @(negedge clk);
      sym_valid = 1'b0;
      if (rx_m) begin
         for (int i = 0; i < N - 1; i++) win_m[i] = win_m[i+1];
         win_m[N-1] = c;
         if (fill_m < N) fill_m++;
         score_m = model_score();
      end else begin
         score_m = 0;
      end
      exp_det = rx_m && (fill_m == N) && (score_m <= 2 * tol_m);
      @(negedge clk);
      check(score == SW'(score_m), "R2 score", int'(score), score_m);
      check(detect == exp_det, (fill_m < N) ? "R6 detect" : "R3 detect",
            int'(detect), int'(exp_det));
      if (exp_det) begin
         @(negedge clk);
         check(detect == 1'b0, "R5 pulse width", int'(detect), 0);
      end
   endtask

   // send the pattern with err_m[i] steps of error at position i
   task automatic send_frame();
      for (int i = 0; i < N; i++)
         send(err_m[i] == 0 ? pat_m[i] : bend(pat_m[i], err_m[i]));
   endtask

   task automatic clear_err();
      for (int i = 0; i < N; i++) err_m[i] = 0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'h5A17C3));
      for (int i = 0; i < N; i++) begin
         win_m[i] = 2'b00;
         pat_m[i] = 2'($urandom_range(0, 3));
      end
      clear_err();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(detect == 1'b0, "R7 reset detect", int'(detect), 0);
      check(score == '0, "R7 reset score", int'(score), 0);

      load_pat();
      set_rx(1'b1);

      // R4: default limit 4 -- score 4 hits (last symbol), then score 5 misses
      err_m[3] = 2; err_m[10] = 2;
      send_frame();
      clear_err();
      err_m[0] = 2; err_m[5] = 2; err_m[20] = 1;
      send_frame();

      // R3 limit 0: exact hit, one step misses
      set_tol(0);
      clear_err();
      send_frame();
      err_m[23] = 1;
      send_frame();

      // R3 limit 2 boundary
      set_tol(1);
      clear_err(); err_m[7] = 1; err_m[8] = 1;
      send_frame();
      err_m[9] = 1;
      send_frame();

      // R3 limit 6 boundary, two-step weights (R1)
      set_tol(3);
      clear_err(); err_m[1] = 2; err_m[2] = 2; err_m[4] = 2;
      send_frame();
      err_m[6] = 1;
      send_frame();

      // R1 worst case: pattern all +3, window all -3 -> 72
      for (int i = 0; i < N; i++) pat_m[i] = 2'b01;
      load_pat();
      for (int i = 0; i < N; i++) send(2'b11);
      check(score == SW'(72), "R1 worst score", int'(score), 72);

      // R8: new pattern takes effect for the next score
      for (int i = 0; i < N; i++) pat_m[i] = 2'b11;
      load_pat();
      send(2'b11);
      check(score == '0, "R8 new pattern", int'(score), 0);

      // R7: symbols ignored while receive is off
      set_rx(1'b0);
      check(score == '0, "R7 score off", int'(score), 0);
      send(2'b01); send(2'b10);
      check(detect == 1'b0, "R7 detect off", int'(detect), 0);

      // R6: re-entry needs a full window again
      set_rx(1'b1);
      clear_err();
      send_frame();

      // R9: idle cycles do not move the score
      repeat (5) @(negedge clk);
      check(score == SW'(score_m), "R9 idle hold", int'(score), score_m);

      // random stream biased toward the pattern
      for (int i = 0; i < N; i++) pat_m[i] = 2'($urandom_range(0, 3));
      load_pat();
      for (int k = 0; k < 1200; k++) begin
         logic [1:0] c;
         if ($urandom_range(0, 199) == 0) set_tol($urandom_range(0, 3));
         if ($urandom_range(0, 299) == 0) begin
            set_rx(1'b0);
            set_rx(1'b1);
         end
         if ($urandom_range(0, 99) < 88) c = pat_m[k % N];
         else c = 2'($urandom_range(0, 3));
         send(c);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule